// File: doc/BRIEF.md
# SDR SDRAM Power-Up and Refresh Sequencer

This block owns the command pins of one rank of single-data-rate SDRAM (4 banks, 12-bit row address, 10-bit column address) during the two phases that need no host traffic. After a synchronous reset it drives clock enable and the device start-up script: a long settling wait, a precharge of every bank, a burst of auto-refresh commands, and a mode-register load. After that it raises a done flag.

Once the device is ready, an interval timer counts down from a reload value taken from an input port. When the timer expires the block raises a refresh request toward an external access arbiter. It sends the auto-refresh command only after the arbiter grants the slot. Every command is held apart from the previous one by clock counts given as parameters. A NOP is driven on each cycle in between.

The settling wait equals clock frequency times wait time, divided by a scale factor. Simulation uses the scale factor to shorten the wait.

Top module: `sdr_boot_refresh_seq`

## Requirements
- R1: While reset is high, the outputs are: clock enable low, command NOP (`{cs_n,ras_n,cas_n,we_n}` = 0111), init_done low, refresh_req low.
- R2: Clock enable rises on the first clock edge after reset is released and stays high. The precharge-all command appears PWRUP_CYCLES edges after clock enable rises.
- R3: Precharge-all is encoded 0010, with address bit 10 high.
- R4: Exactly four auto-refresh commands (0001) follow the precharge-all. The first comes T_RP edges after the precharge, and each later one comes T_RC edges after the one before it.
- R5: The mode-register load (0000) comes T_RC edges after the fourth start-up refresh. It carries bank address 0 and address word 0x231: burst-length code 1 in bits 2:0, sequential order (bit 3 = 0), CAS latency 3 in bits 6:4, and single-location writes (bit 9 = 1).
- R6: init_done rises T_MRD edges after the mode-register load and then stays high.
- R7: Every cycle that does not carry one of these commands shows NOP (0111).
- R8: refresh_req is never high before init_done. It rises reload+1 edges after init_done rises, and reload+1 edges after each periodic refresh command.
- R9: refresh_req stays high while refresh_grant is low. The auto-refresh command is issued on the edge that samples refresh_req and refresh_grant both high, and refresh_req falls on that same edge. A grant while no request is pending issues nothing.
- R10: The interval reload value is sampled when init_done rises and whenever a periodic refresh is issued. A change to it affects only the next interval.
- R11: Two periodic refresh commands are never closer than T_RC edges, even when the reload value is smaller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_grant | input | 1 | Arbiter permits a refresh command |
| rfsh_reload | input | 16 | Refresh interval reload value in cycles (0x569 for 15.62 us at 90 MHz less a 20-cycle margin) |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Address bus |
| init_done | output | 1 | Start-up script complete |
| refresh_req | output | 1 | Periodic refresh wanted |

## Verification
Two events can land on the same edge: the interval timer is expiring (or already sitting at zero), and a granted refresh is restarting that timer. The bench holds the grant high so that the issue edge follows the request's rise at once. It then requires the gap between refresh commands to be exactly reload+2 edges, which shows that the restart takes priority over the expired count. With a reload shorter than the row-cycle time, the timer expires while the row-cycle wait is still running. There the bench requires a gap of exactly T_RC edges.

// File: rtl/sdrs_pkg.sv
package sdrs_pkg;

  // Command code on {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR  = 4'b0000,
    CMD_AREF = 4'b0001,
    CMD_PALL = 4'b0010,
    CMD_NOP  = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWR,
    ST_PALL,
    ST_AREF,
    ST_MRD,
    ST_RUN
  } seq_st_e;

  // Builds the device mode word from its fields
  function automatic logic [11:0] mode_word(
    input logic [2:0] bl_code,
    input logic       interleave,
    input logic [2:0] cas_lat,
    input logic       wr_single
  );
    logic [11:0] w;
    w       = '0;
    w[2:0]  = bl_code;
    w[3]    = interleave;
    w[6:4]  = cas_lat;
    w[9]    = wr_single;
    return w;
  endfunction

endpackage

// File: rtl/sdrs_interval_timer.sv
module sdrs_interval_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] reload,
  output logic             due
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      cnt <= reload;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign due = run && (cnt == '0);

  // R8
  due_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (due && !restart) |=> due);

endmodule

// File: rtl/sdrs_script_fsm.sv
module sdrs_script_fsm
  import sdrs_pkg::*;
#(
  parameter int          ROW_BITS     = 12,
  parameter int          BANK_BITS    = 2,
  parameter int          PWRUP_CYCLES = 9000000,
  parameter int          T_RP         = 3,
  parameter int          T_RC         = 10,
  parameter int          T_MRD        = 2,
  parameter int          INIT_AREFS   = 4,
  parameter logic [11:0] MODE_WORD    = 12'h231
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 refresh_grant,
  input  logic                 timer_due,
  output logic                 timer_restart,
  output logic                 cke,
  output sd_cmd_e              cmd,
  output logic [BANK_BITS-1:0] ba,
  output logic [ROW_BITS-1:0]  addr,
  output logic                 init_done,
  output logic                 refresh_req
);

  localparam int MAX_A    = (PWRUP_CYCLES > T_RC) ? PWRUP_CYCLES : T_RC;
  localparam int MAX_B    = (MAX_A > T_RP) ? MAX_A : T_RP;
  localparam int WAIT_MAX = (MAX_B > T_MRD) ? MAX_B : T_MRD;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int AR_W     = $clog2(INIT_AREFS + 1);
  localparam int ALL_BIT  = 10;

  seq_st_e           state;
  logic [WAIT_W-1:0] wait_cnt;
  logic [AR_W-1:0]   aref_cnt;
  logic              wait_zero;
  logic              issue;

  assign wait_zero     = (wait_cnt == '0);
  assign issue         = (state == ST_RUN) && refresh_req && refresh_grant && wait_zero;
  assign timer_restart = issue;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cke         <= 1'b0;
      cmd         <= CMD_NOP;
      ba          <= '0;
      addr        <= '0;
      wait_cnt    <= '0;
      aref_cnt    <= '0;
      init_done   <= 1'b0;
      refresh_req <= 1'b0;
    end else begin
      cmd  <= CMD_NOP;
      ba   <= '0;
      addr <= '0;
      if (!wait_zero) wait_cnt <= wait_cnt - 1'b1;
      unique case (state)
        ST_IDLE: begin
          cke      <= 1'b1;
          wait_cnt <= WAIT_W'(PWRUP_CYCLES - 1);
          state    <= ST_PWR;
        end
        ST_PWR: if (wait_zero) begin
          cmd           <= CMD_PALL;
          addr[ALL_BIT] <= 1'b1;
          wait_cnt      <= WAIT_W'(T_RP - 1);
          state         <= ST_PALL;
        end
        ST_PALL: if (wait_zero) begin
          cmd      <= CMD_AREF;
          aref_cnt <= AR_W'(1);
          wait_cnt <= WAIT_W'(T_RC - 1);
          state    <= ST_AREF;
        end
        ST_AREF: if (wait_zero) begin
          if (aref_cnt < AR_W'(INIT_AREFS)) begin
            cmd      <= CMD_AREF;
            aref_cnt <= aref_cnt + 1'b1;
            wait_cnt <= WAIT_W'(T_RC - 1);
          end else begin
            cmd      <= CMD_LMR;
            addr     <= ROW_BITS'(MODE_WORD);
            wait_cnt <= WAIT_W'(T_MRD - 1);
            state    <= ST_MRD;
          end
        end
        ST_MRD: if (wait_zero) begin
          init_done <= 1'b1;
          state     <= ST_RUN;
        end
        ST_RUN: begin
          if (issue) begin
            cmd         <= CMD_AREF;
            wait_cnt    <= WAIT_W'(T_RC - 1);
            refresh_req <= 1'b0;
          end else if (timer_due) begin
            refresh_req <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  cke_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

  // R6
  init_hold_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  // R8
  no_early_req_chk: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !refresh_req);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (refresh_req && !refresh_grant) |=> refresh_req);

  // R9
  granted_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (init_done && cmd == CMD_AREF) |-> $past(refresh_req && refresh_grant));

  // R7
  single_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

  // R3
  pall_all_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PALL) |-> addr[ALL_BIT]);

endmodule

// File: rtl/sdr_boot_refresh_seq.sv
module sdr_boot_refresh_seq
  import sdrs_pkg::*;
#(
  parameter int         ROW_BITS     = 12,
  parameter int         BANK_BITS    = 2,
  parameter int         RELOAD_W     = 16,
  parameter int         CLK_MHZ      = 90,
  parameter int         PWRUP_US     = 100000,
  parameter int         PWRUP_DIV    = 1,
  parameter int         T_RP         = 3,
  parameter int         T_RC         = 10,
  parameter int         T_MRD        = 2,
  parameter int         INIT_AREFS   = 4,
  parameter logic [2:0] BURST_CODE   = 3'd1,
  parameter logic       BURST_ILV    = 1'b0,
  parameter logic [2:0] CAS_LATENCY  = 3'd3,
  parameter logic       WRITE_SINGLE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 refresh_grant,
  input  logic [RELOAD_W-1:0]  rfsh_reload,
  output logic                 sd_cke,
  output logic                 sd_cs_n,
  output logic                 sd_ras_n,
  output logic                 sd_cas_n,
  output logic                 sd_we_n,
  output logic [BANK_BITS-1:0] sd_ba,
  output logic [ROW_BITS-1:0]  sd_addr,
  output logic                 init_done,
  output logic                 refresh_req
);

  localparam int          PWRUP_CYCLES = CLK_MHZ * PWRUP_US / PWRUP_DIV;
  localparam logic [11:0] MODE_VAL     =
    mode_word(BURST_CODE, BURST_ILV, CAS_LATENCY, WRITE_SINGLE);

  sd_cmd_e cmd_q;
  logic    t_due;
  logic    t_restart;

  sdrs_script_fsm #(
    .ROW_BITS     (ROW_BITS),
    .BANK_BITS    (BANK_BITS),
    .PWRUP_CYCLES (PWRUP_CYCLES),
    .T_RP         (T_RP),
    .T_RC         (T_RC),
    .T_MRD        (T_MRD),
    .INIT_AREFS   (INIT_AREFS),
    .MODE_WORD    (MODE_VAL)
  ) fsm_i (
    .clk           (clk),
    .rst           (rst),
    .refresh_grant (refresh_grant),
    .timer_due     (t_due),
    .timer_restart (t_restart),
    .cke           (sd_cke),
    .cmd           (cmd_q),
    .ba            (sd_ba),
    .addr          (sd_addr),
    .init_done     (init_done),
    .refresh_req   (refresh_req)
  );

  sdrs_interval_timer #(
    .CNT_W (RELOAD_W)
  ) timer_i (
    .clk     (clk),
    .rst     (rst),
    .run     (init_done),
    .restart (t_restart),
    .reload  (rfsh_reload),
    .due     (t_due)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

endmodule

// File: tb/sdr_boot_refresh_seq_tb_top.sv
module sdr_boot_refresh_seq_tb_top;

  localparam int P_DIV  = 225000;
  localparam int P_CYC  = 90 * 100000 / P_DIV;   // 40
  localparam int T_RP   = 3;
  localparam int T_RC   = 10;
  localparam int T_MRD  = 2;
  localparam int E_PRE  = 1 + P_CYC;
  localparam int E_REF1 = E_PRE + T_RP;
  localparam int E_LMR  = E_REF1 + 3 * T_RC + T_RC;
  localparam int E_DONE = E_LMR + T_MRD;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        grant = 1'b0;
  logic [15:0] reload = 16'h0569;
  logic        cke, cs_n, ras_n, cas_n, we_n, done, req;
  logic [1:0]  ba;
  logic [11:0] addr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sdr_boot_refresh_seq #(.PWRUP_DIV(P_DIV)) dut_i (
    .clk (clk), .rst (rst), .refresh_grant (grant), .rfsh_reload (reload),
    .sd_cke (cke), .sd_cs_n (cs_n), .sd_ras_n (ras_n), .sd_cas_n (cas_n),
    .sd_we_n (we_n), .sd_ba (ba), .sd_addr (addr),
    .init_done (done), .refresh_req (req)
  );

  function automatic int pins();
    return int'({cs_n, ras_n, cas_n, we_n});
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) step();
    chk(cke == 1'b0, "R1", "cke in reset", int'(cke), 0);
    chk(pins() == 7, "R1", "command in reset", pins(), 7);
    chk(done == 1'b0, "R1", "init_done in reset", int'(done), 0);
    chk(req == 1'b0, "R1", "refresh_req in reset", int'(req), 0);
  endtask

  task automatic t_init();
    int nop_bad = 0, nop_act = 0, cke_bad = 0, done_bad = 0;
    rst = 1'b0;
    for (int e = 1; e <= E_DONE + 2; e++) begin
      step();
      if (cke !== 1'b1) cke_bad++;
      if (done !== (e >= E_DONE)) done_bad++;
      if (e == E_PRE) begin
        chk(pins() == 2, "R3", "precharge code", pins(), 2);
        chk(addr[10] == 1'b1, "R3", "precharge A10", int'(addr[10]), 1);
        chk(pins() == 2, "R2", "precharge after power-up wait", pins(), 2);
      end else if (e >= E_REF1 && e < E_LMR && ((e - E_REF1) % T_RC) == 0) begin
        chk(pins() == 1, "R4", $sformatf("start-up refresh at edge %0d", e), pins(), 1);
      end else if (e == E_LMR) begin
        chk(pins() == 0, "R5", "mode load code", pins(), 0);
        chk(addr == 12'h231, "R5", "mode word", int'(addr), 'h231);
        chk(ba == 2'd0, "R5", "mode bank", int'(ba), 0);
      end else if (pins() != 7) begin
        if (nop_bad == 0) nop_act = pins();
        nop_bad++;
      end
      if (e == E_DONE - 1)
        chk(done == 1'b0, "R6", "init_done before tMRD", int'(done), 0);
      if (e == E_DONE)
        chk(done == 1'b1, "R6", "init_done after tMRD", int'(done), 1);
    end
    chk(nop_bad == 0, "R7", "NOP between start-up commands", nop_act, 7);
    chk(cke_bad == 0, "R2", "cke high throughout", cke_bad, 0);
    chk(done_bad == 0, "R6", "init_done timing", done_bad, 0);
  endtask

  // counts edges until refresh_req is high
  task automatic wait_req(output int n);
    n = 0;
    while (!req && n < 5000) begin
      step();
      n++;
    end
  endtask

  task automatic t_first_req();
    int n, bad = 0;
    grant = 1'b0;
    wait_req(n);
    chk(n == 16'h0569 - 2 + 1, "R8", "request after init_done", n + 2, 16'h0569 + 1);
    for (int i = 0; i < 20; i++) begin
      step();
      if (!req || pins() != 7) bad++;
    end
    chk(bad == 0, "R9", "request held, no command without grant", bad, 0);
    grant = 1'b1;
    step();
    grant = 1'b0;
    chk(pins() == 1, "R9", "refresh on grant", pins(), 1);
    chk(req == 1'b0, "R9", "request drops on issue", int'(req), 0);
    wait_req(n);
    chk(n == 16'h0569 + 1, "R8", "request after refresh", n, 16'h0569 + 1);
  endtask

  task automatic t_stray_grant();
    grant = 1'b1;
    step();
    grant = 1'b0;
    chk(pins() == 1, "R9", "pending request served", pins(), 1);
    step();
    grant = 1'b1;
    step();
    grant = 1'b0;
    chk(pins() == 7, "R9", "stray grant issues nothing", pins(), 7);
    chk(req == 1'b0, "R9", "stray grant leaves request low", int'(req), 0);
  endtask

  task automatic gap(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (pins() != 1 && n < 5000);
  endtask

  task automatic t_back_to_back();
    int n;
    wait_req(n);
    reload = 16'd100;
    grant  = 1'b1;
    step();
    chk(pins() == 1, "R9", "issue with held grant", pins(), 1);
    gap(n);
    chk(n == 102, "R10", "gap after new reload", n, 102);
    gap(n);
    chk(n == 102, "R8", "timer restart wins over expiry", n, 102);
  endtask

  task automatic t_min_spacing();
    int n;
    reload = 16'd3;
    gap(n);
    chk(n == 102, "R10", "reload change waits for next restart", n, 102);
    gap(n);
    chk(n == T_RC, "R11", "short reload bounded by tRC", n, T_RC);
    gap(n);
    chk(n == T_RC, "R11", "short reload bounded by tRC again", n, T_RC);
    grant = 1'b0;
  endtask

  initial begin
    t_reset();
    t_init();
    t_first_req();
    t_stray_grant();
    t_back_to_back();
    t_min_spacing();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule